// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one read or write transfer at a time on a bus whose low lines carry first the address and then the data. The requester presents an address, a memory-or-I/O flag, a direction and, for a write, the data to send. The sequencer then steps through four phases, one clock each: address, setup, data and completion. Between setup and data it inserts as many wait phases as the target asks for through its ready input.

The block produces all the strobes an external address latch and data transceiver need: a latch strobe, active-low read, write and data-enable strobes, a transceiver direction line, a memory/I-O select, the upper address lines, and a drive enable with its value for the shared lines. On a read it captures the value on the shared lines in the data phase. It returns that value with a one-clock done pulse. A parameter can bound the number of wait phases. When the bound is reached, the cycle finishes anyway and is flagged as an error.

Each phase lasts one clock. The reset input is asserted asynchronously. Its release is synchronised inside the block, so the block leaves reset two clocks after `rst_n` rises.

Top module: `bus_cycle_seq`

## Requirements
- R1: While in reset and after it, with no request pending, the outputs are idle. `req_ready`=1, `done`=0, `wait_err`=0. `ale`=0. `rd_n`, `wr_n` and `den_n` are all 1. `dtr`=1. `mio`=0, `ad_oe`=0, `ad_out`=0 and `a_hi`=0.
- R2: A request is taken when `req_valid`=1 and `req_ready`=1 at a rising edge. The address phase fills the next clock. In that phase `ale`=1, `ad_oe`=1 and `ad_out` holds the low DW address bits. `ale` is 0 in every other phase. With no waits the cycle lasts exactly four clocks. `a_hi` holds the upper AW-DW address bits from the address phase through completion.
- R3: `mio` equals the request's memory flag (1 = memory, 0 = I/O) from the address phase through completion. `dtr` is 1 for a write and 0 for a read over the same span.
- R4: For a read, `ad_oe`=0 from the setup phase through completion. `rd_n`=0 in the setup, wait and data phases, and returns to 1 in completion. `wr_n` stays 1 for the whole cycle.
- R5: For a write, `ad_oe`=1 and `ad_out` carries the write data from the setup phase through completion. `wr_n`=0 in the setup, wait and data phases, and returns to 1 in completion. `rd_n` stays 1 for the whole cycle.
- R6: `den_n`=0 in the setup, wait and data phases of any cycle, and 1 in the address and completion phases.
- R7: `ready_in` is sampled at the end of the setup phase and at the end of each wait phase. Each low sample adds one wait phase, and the first high sample leads into the data phase. A cycle with N wait phases lasts 4+N clocks.
- R8: During a wait phase every bus output keeps the value it had in the preceding phase.
- R9: For a read, `ad_in` is captured at the end of the data phase. It appears on `rdata` while `done`=1.
- R10: `done` is 1 for exactly one clock, in the completion phase. `req_ready` is 0 from the address phase through completion. A request raised while the block is busy starts no cycle.
- R11: If MAX_WAIT is nonzero and MAX_WAIT wait phases have passed with `ready_in` still low, the data phase follows anyway. In that case `wait_err`=1 during the `done` clock. Otherwise `wait_err` is 0. MAX_WAIT=0 means no bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | AW | Transfer address |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | Read data, valid with done |
| wait_err | output | 1 | Wait bound reached, valid with done |
| ready_in | input | 1 | Target ready, sampled at end of setup and wait phases |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| dtr | output | 1 | Transceiver direction, 1 = transmit |
| mio | output | 1 | Memory/I-O select |
| a_hi | output | AW-DW | Upper address lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_out | output | DW | Value driven on the shared lines |
| ad_in | input | DW | Value seen on the shared lines |

## Verification
The assertions assume that `ready_in` is a clean level at every rising edge. They also assume that `req_addr`, `req_mem`, `req_write` and `req_wdata` are settled whenever `req_valid` is high. The bench meets both assumptions by changing every input only on the falling clock edge. It drives `ready_in` from a count of phases since the address phase, so the number of low samples is exact. It drives `ad_in` with the expected read value only in the data phase and with its complement in every other phase, so a capture taken one phase early or late returns the wrong data.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_SETUP = 3'd2,
    PH_WAIT  = 3'd3,
    PH_DATA  = 3'd4,
    PH_DONE  = 3'd5
  } phase_e;
endpackage

// File: rtl/bcs_phase_fsm.sv
module bcs_phase_fsm
  import bcs_pkg::*;
#(
  parameter int MAX_WAIT = 7
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   ready_in,
  output phase_e phase,
  output logic   err
);
  localparam int WCW = (MAX_WAIT > 0) ? $clog2(MAX_WAIT + 1) : 1;
  localparam logic [WCW-1:0] LIM = WCW'((MAX_WAIT > 0) ? MAX_WAIT - 1 : 0);
  localparam logic BOUNDED = (MAX_WAIT > 0);

  phase_e         phase_q, phase_d;
  logic [WCW-1:0] wcnt_q, wcnt_d;
  logic           err_q, err_d;
  logic           limit_hit;

  assign limit_hit = BOUNDED && (wcnt_q == LIM);

  always_comb begin
    phase_d = phase_q;
    wcnt_d  = wcnt_q;
    err_d   = err_q;
    unique case (phase_q)
      PH_IDLE: if (start) begin
        phase_d = PH_ADDR;
        err_d   = 1'b0;
      end
      PH_ADDR:  phase_d = PH_SETUP;
      PH_SETUP: begin
        wcnt_d  = '0;
        phase_d = ready_in ? PH_DATA : PH_WAIT;
      end
      PH_WAIT: begin
        if (ready_in) begin
          phase_d = PH_DATA;
        end else if (limit_hit) begin
          phase_d = PH_DATA;
          err_d   = 1'b1;
        end else begin
          wcnt_d  = wcnt_q + 1'b1;
        end
      end
      PH_DATA:  phase_d = PH_DONE;
      PH_DONE:  phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wcnt_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      wcnt_q  <= wcnt_d;
      err_q   <= err_d;
    end
  end

  assign phase = phase_q;
  assign err   = err_q;

  // R7: a low sample at the end of setup inserts a wait phase
  a_r7_low_gives_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETUP && !ready_in) |=> (phase_q == PH_WAIT));
  // R7: a high sample at the end of a wait phase leads into the data phase
  a_r7_high_ends_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT && ready_in) |=> (phase_q == PH_DATA && !err_q));
  // R11: the wait counter never passes the bound
  a_r11_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT && BOUNDED) |-> (wcnt_q <= LIM));
  // R2: the address phase is always followed by the setup phase
  a_r2_addr_then_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ADDR) |=> (phase_q == PH_SETUP));
endmodule

// File: rtl/bcs_req_hold.sv
module bcs_req_hold
  import bcs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  phase_e        phase,
  input  logic [AW-1:0] req_addr,
  input  logic          req_mem,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] ad_in,
  output logic [AW-1:0] addr,
  output logic          mem,
  output logic          write,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic cap_en;

  assign cap_en = (phase == PH_DATA) && !write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      mem   <= 1'b0;
      write <= 1'b0;
      wdata <= '0;
    end else if (start) begin
      addr  <= req_addr;
      mem   <= req_mem;
      write <= req_write;
      wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (cap_en) begin
      rdata <= ad_in;
    end
  end

  // R9: read data changes only on the edge that closes a data phase
  a_r9_capture_time: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_DATA) |=> $stable(rdata));
endmodule

// File: rtl/bcs_pin_decode.sv
module bcs_pin_decode
  import bcs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase,
  input  logic [AW-1:0]    addr,
  input  logic             mem,
  input  logic             write,
  input  logic [DW-1:0]    wdata,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             den_n,
  output logic             dtr,
  output logic             mio,
  output logic [AW-DW-1:0] a_hi,
  output logic             ad_oe,
  output logic [DW-1:0]    ad_out
);
  logic active, strobe_win;

  assign active     = (phase != PH_IDLE);
  assign strobe_win = (phase == PH_SETUP) || (phase == PH_WAIT) || (phase == PH_DATA);

  always_comb begin
    ale    = (phase == PH_ADDR);
    rd_n   = !(strobe_win && !write);
    wr_n   = !(strobe_win && write);
    den_n  = !strobe_win;
    dtr    = active ? write : 1'b1;
    mio    = active && mem;
    a_hi   = active ? addr[AW-1:DW] : '0;
    ad_oe  = 1'b0;
    ad_out = '0;
    if (phase == PH_ADDR) begin
      ad_oe  = 1'b1;
      ad_out = addr[DW-1:0];
    end else if (active && write) begin
      ad_oe  = 1'b1;
      ad_out = wdata;
    end
  end

  // R4 R5: read and write strobes never both low
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  // R8: bus outputs are held through a wait phase
  a_r8_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT) |-> ($stable(rd_n) && $stable(wr_n) && $stable(den_n)
      && $stable(ad_oe) && $stable(ad_out) && $stable(dtr) && $stable(mio)));
  // R4: shared lines are released while reading past the address phase
  a_r4_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n) |-> !ad_oe);
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 16,
  parameter int MAX_WAIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_mem,
  input  logic             req_write,
  input  logic [DW-1:0]    req_wdata,
  output logic             done,
  output logic [DW-1:0]    rdata,
  output logic             wait_err,
  input  logic             ready_in,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             den_n,
  output logic             dtr,
  output logic             mio,
  output logic [AW-DW-1:0] a_hi,
  output logic             ad_oe,
  output logic [DW-1:0]    ad_out,
  input  logic [DW-1:0]    ad_in
);
  logic          rs_meta, rs_n;
  phase_e        phase;
  logic          err, start;
  logic [AW-1:0] h_addr;
  logic          h_mem, h_write;
  logic [DW-1:0] h_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;
  assign done      = (phase == PH_DONE);
  assign wait_err  = done && err;

  bcs_phase_fsm #(.MAX_WAIT(MAX_WAIT)) u_fsm (
    .clk(clk), .rst_n(rs_n), .start(start), .ready_in(ready_in),
    .phase(phase), .err(err)
  );

  bcs_req_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk(clk), .rst_n(rs_n), .start(start), .phase(phase),
    .req_addr(req_addr), .req_mem(req_mem), .req_write(req_write),
    .req_wdata(req_wdata), .ad_in(ad_in),
    .addr(h_addr), .mem(h_mem), .write(h_write), .wdata(h_wdata),
    .rdata(rdata)
  );

  bcs_pin_decode #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst_n(rs_n), .phase(phase), .addr(h_addr), .mem(h_mem),
    .write(h_write), .wdata(h_wdata), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .den_n(den_n), .dtr(dtr), .mio(mio), .a_hi(a_hi), .ad_oe(ad_oe),
    .ad_out(ad_out)
  );

  // R10: done lasts one clock and is followed by idle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rs_n)
    done |=> (!done && req_ready));
  // R2: an accepted request opens an address phase with the latch strobe
  a_r2_start_ale: assert property (@(posedge clk) disable iff (!rs_n)
    start |=> (ale && !req_ready));
endmodule

// File: tb/test_bus_cycle_seq.sv
`timescale 1ns/1ps
module test_bus_cycle_seq;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int MW = 3;

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_mem, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rdata, ad_out, ad_in;
  logic          done, wait_err, ready_in;
  logic          ale, rd_n, wr_n, den_n, dtr, mio, ad_oe;
  logic [AW-DW-1:0] a_hi;

  int tests = 0;
  int fails = 0;

  bus_cycle_seq #(.AW(AW), .DW(DW), .MAX_WAIT(MW)) i_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mem(req_mem), .req_write(req_write),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .wait_err(wait_err),
    .ready_in(ready_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n),
    .dtr(dtr), .mio(mio), .a_hi(a_hi), .ad_oe(ad_oe), .ad_out(ad_out),
    .ad_in(ad_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(req_ready == 1'b1, {tag, " req_ready"}, int'(req_ready), 1);
    chk(done == 1'b0 && wait_err == 1'b0, {tag, " done/err"}, int'({done, wait_err}), 0);
    chk({ale, rd_n, wr_n, den_n, dtr, mio, ad_oe} == 7'b0111100,
        {tag, " strobes"}, int'({ale, rd_n, wr_n, den_n, dtr, mio, ad_oe}), 'h3c);
    chk(ad_out == '0 && a_hi == '0, {tag, " lines"}, int'({a_hi, ad_out}), 0);
  endtask

  // nwait: low ready samples offered; busy_req: raise a request mid-cycle
  task automatic run_cycle(input logic [AW-1:0] a, input bit m, input bit w,
                           input logic [DW-1:0] wd, input logic [DW-1:0] rv,
                           input int nwait, input bit busy_req);
    int wn;
    bit exp_err;
    wn      = (nwait > MW) ? MW : nwait;
    exp_err = (nwait > MW);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_mem = m; req_write = w; req_wdata = wd;
    chk(req_ready == 1'b1, "R10 ready before request", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~wd;
    for (int k = 0; k <= 3 + wn; k++) begin
      bit sw, exp_oe;
      logic [DW-1:0] exp_ad;
      sw     = (k >= 1) && (k <= 2 + wn);
      exp_oe = (k == 0) || w;
      exp_ad = (k == 0) ? a[DW-1:0] : wd;
      ready_in = ((k - 1) >= nwait);
      ad_in    = (k == 2 + wn) ? rv : ~rv;
      if (busy_req) req_valid = (k >= 1 && k <= 2);
      chk(ale == (k == 0), $sformatf("R2 ale k=%0d", k), int'(ale), int'(k == 0));
      chk(ad_oe == exp_oe, $sformatf("R4 R5 ad_oe k=%0d", k), int'(ad_oe), int'(exp_oe));
      if (exp_oe)
        chk(ad_out == exp_ad, $sformatf("R2 R5 ad_out k=%0d", k), int'(ad_out), int'(exp_ad));
      chk(a_hi == a[AW-1:DW], $sformatf("R2 a_hi k=%0d", k), int'(a_hi), int'(a[AW-1:DW]));
      chk(mio == m && dtr == w, $sformatf("R3 mio/dtr k=%0d", k), int'({mio, dtr}), int'({m, w}));
      chk(rd_n == !(sw && !w), $sformatf("R4 rd_n k=%0d", k), int'(rd_n), int'(!(sw && !w)));
      chk(wr_n == !(sw && w), $sformatf("R5 wr_n k=%0d", k), int'(wr_n), int'(!(sw && w)));
      chk(den_n == !sw, $sformatf("R6 R8 den_n k=%0d", k), int'(den_n), int'(!sw));
      chk(done == (k == 3 + wn), $sformatf("R7 R10 done k=%0d w=%0d", k, wn), int'(done), int'(k == 3 + wn));
      chk(req_ready == 1'b0, $sformatf("R10 busy k=%0d", k), int'(req_ready), 0);
      if (k == 3 + wn) begin
        chk(wait_err == exp_err, "R11 wait_err", int'(wait_err), int'(exp_err));
        if (!w) chk(rdata == rv, "R9 rdata", int'(rdata), int'(rv));
      end
      @(negedge clk);
    end
    ready_in = 1'b0;
    chk_idle("R1 R10 after cycle");
    if (busy_req) begin
      @(negedge clk);
      chk(ale == 1'b0 && req_ready == 1'b1, "R10 busy request ignored", int'({ale, req_ready}), 1);
    end
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_mem = 1'b0;
    req_write = 1'b0; req_wdata = '0; ready_in = 1'b0; ad_in = '0;
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle("R1 after reset");
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int n = 0; n <= MW + 2; n++) begin
          logic [AW-1:0] a;
          logic [DW-1:0] wd, rv;
          a  = AW'(32'h5A3C1 + 32'h1111 * (m * 16 + w * 8 + n));
          wd = DW'(16'hC0DE ^ (16'h0101 * n) ^ (w ? 16'h8000 : 16'h0));
          rv = DW'(16'h3E71 + 16'h0F0F * n + 16'h100 * m);
          run_cycle(a, m[0], w[0], wd, rv, n, 1'b0);
        end
    run_cycle(20'hF00F5, 1'b1, 1'b0, 16'h0, 16'hBEEF, 1, 1'b1);
    run_cycle(20'h0ABCD, 1'b0, 1'b1, 16'h1234, 16'h0, 0, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule